// File: doc/BRIEF.md
# Store Buffer with Load Forwarding and Fence

This block sits between one in-order processor request port and one shared memory port. Stores from the processor go into a small FIFO and are written to memory later, one per cycle, in the order they were accepted. A load does not wait for those writes. It first searches the FIFO. If one or more buffered stores have the same word address, the load takes the data of the youngest of them and answers at once. If none match, the load is sent to memory ahead of the stores that are still waiting.

The result is that a later read may pass an earlier write, while writes never pass each other. A fence request is held off until the FIFO is empty and no load is in flight. Software uses it wherever it needs full ordering. The buffered values stay private to the issuing processor until the memory port has accepted the write.

Top module: `sb_tso_top`

## Requirements
- R1: A load (`cpu_op` = 2'b00) whose word address matches one or more buffered stores is answered from the youngest matching store, with `rsp_valid` high in the cycle right after the request is accepted.
- R2: Every accepted store (`cpu_op` = 2'b01) appears exactly once as a write on the memory port (`mem_we` = 1), and writes appear in the order the stores were accepted.
- R3: A load that matches no buffered store is issued as a memory read (`mem_we` = 0) even while older stores are still buffered. Its response carries the data the memory returned.
- R4: A buffered store does not change memory until its write has been handshaken on the memory port. The port never presents a write while the buffer is empty.
- R5: While DEPTH stores are buffered, `cpu_ready` is low for a store request. A load request is still accepted.
- R6: A fence (`cpu_op` = 2'b10 or 2'b11) is accepted only when the buffer is empty and no load is outstanding. By the time it is accepted, every earlier store has been written to memory.
- R7: At most one memory read is outstanding. From the acceptance of a load that misses until its response, `cpu_ready` is low for every request.
- R8: When a pending load read and a buffered store both want the memory port, the load goes first. The store goes first only if the buffer is full or a fence is waiting at the processor port.
- R9: During and right after reset, `rsp_valid` and `mem_valid` are low, the buffer is empty and `cpu_ready` is high for loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request valid |
| cpu_ready | output | 1 | Request accepted this cycle when high together with valid |
| cpu_op | input | 2 | 00 load, 01 store, 1x fence |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Store data |
| rsp_valid | output | 1 | Load response valid, one-cycle pulse |
| rsp_data | output | DATA_W | Load response data |
| mem_valid | output | 1 | Memory request valid |
| mem_ready | input | 1 | Memory accepts request |
| mem_we | output | 1 | 1 write (store drain), 0 read (load) |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |

## Verification
The forwarding path is exercised with two stores to the same address followed by a load, which tells youngest-match selection apart from oldest-match selection. It is also exercised with a load to an address that is not buffered, which tells a forwarded answer apart from a memory answer. With memory writes stalled, a store and a load to a different address show that the read passes the pending write while memory still holds the old value. Filling the buffer and then issuing a missing load shows the drain taking priority while the buffer is full, and a fence held against a stalled drain shows that it waits for the buffer to empty. The order of all writes seen at the memory port is compared with the order in which the stores were accepted.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    OP_LOAD   = 2'b00,
    OP_STORE  = 2'b01,
    OP_FENCE  = 2'b10,
    OP_FENCE2 = 2'b11
  } sb_op_e;

  typedef enum logic [1:0] {
    LD_IDLE = 2'b00,
    LD_REQ  = 2'b01,
    LD_WAIT = 2'b10
  } ld_state_e;
endpackage

// File: rtl/sb_store_fifo.sv
module sb_store_fifo #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push_en,
  input  logic [ADDR_W-1:0] push_addr,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop_en,
  input  logic [ADDR_W-1:0] look_addr,
  output logic              full,
  output logic              empty,
  output logic [CNT_W-1:0]  count,
  output logic [ADDR_W-1:0] head_addr,
  output logic [DATA_W-1:0] head_data,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W:0] DEPTH_X = (PTR_W + 1)'(DEPTH);
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [ADDR_W-1:0] addr_q [DEPTH];
  logic [DATA_W-1:0] data_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_en) wr_ptr <= ptr_next(wr_ptr);
      if (pop_en)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_en, pop_en})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // storage without reset so it maps onto plain memory
  always_ff @(posedge clk) begin
    if (push_en) begin
      addr_q[wr_ptr] <= push_addr;
      data_q[wr_ptr] <= push_data;
    end
  end

  assign full      = (count == DEPTH_C);
  assign empty     = (count == '0);
  assign head_addr = addr_q[rd_ptr];
  assign head_data = data_q[rd_ptr];

  // walk from oldest to youngest; the last match wins
  logic [PTR_W:0] slot;
  always_comb begin
    hit      = 1'b0;
    hit_data = '0;
    slot     = '0;
    for (int i = 0; i < DEPTH; i++) begin
      slot = {1'b0, rd_ptr} + (PTR_W + 1)'(i);
      if (slot >= DEPTH_X) slot = slot - DEPTH_X;
      if ((CNT_W'(i) < count) && (addr_q[slot[PTR_W-1:0]] == look_addr)) begin
        hit      = 1'b1;
        hit_data = data_q[slot[PTR_W-1:0]];
      end
    end
  end
endmodule

// File: rtl/sb_load_ctrl.sv
module sb_load_ctrl
  import sb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              buf_full,
  input  logic              buf_empty,
  input  logic              fence_wait,
  input  logic              mem_ready,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              rd_want,
  output logic              grant,
  output logic [ADDR_W-1:0] ld_addr,
  output logic              done,
  output logic [DATA_W-1:0] done_data
);
  ld_state_e state;

  assign busy      = (state != LD_IDLE);
  assign rd_want   = (state == LD_REQ);
  assign grant     = rd_want && (buf_empty || !(buf_full || fence_wait));
  assign done      = (state == LD_WAIT) && mem_rvalid;
  assign done_data = mem_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= LD_IDLE;
      ld_addr <= '0;
    end else begin
      case (state)
        LD_IDLE: if (start) begin
          state   <= LD_REQ;
          ld_addr <= start_addr;
        end
        LD_REQ:  if (grant && mem_ready) state <= LD_WAIT;
        LD_WAIT: if (mem_rvalid) state <= LD_IDLE;
        default: state <= LD_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sb_tso_top.sv
module sb_tso_top
  import sb_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_valid,
  output logic              cpu_ready,
  input  logic [1:0]        cpu_op,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              is_load, is_store, is_fence, accept;
  logic              buf_full, buf_empty, fwd_hit, push, pop, drain;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [ADDR_W-1:0] head_addr, ld_addr;
  logic [DATA_W-1:0] head_data, fwd_data, ld_done_data;
  logic              ld_busy, ld_req, ld_grant, ld_done, ld_take, ld_start;

  assign is_load  = (sb_op_e'(cpu_op) == OP_LOAD);
  assign is_store = (sb_op_e'(cpu_op) == OP_STORE);
  assign is_fence = cpu_op[1];

  always_comb begin
    if (ld_busy)       cpu_ready = 1'b0;
    else if (is_store) cpu_ready = !buf_full;
    else if (is_fence) cpu_ready = buf_empty;
    else               cpu_ready = 1'b1;
  end

  assign accept   = cpu_valid && cpu_ready;
  assign push     = accept && is_store;
  assign ld_take  = accept && is_load;
  assign ld_start = ld_take && !fwd_hit;

  sb_store_fifo #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push),
    .push_addr (cpu_addr),
    .push_data (cpu_wdata),
    .pop_en    (pop),
    .look_addr (cpu_addr),
    .full      (buf_full),
    .empty     (buf_empty),
    .count     (fifo_cnt),
    .head_addr (head_addr),
    .head_data (head_data),
    .hit       (fwd_hit),
    .hit_data  (fwd_data)
  );

  sb_load_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ld (
    .clk        (clk),
    .rst        (rst),
    .start      (ld_start),
    .start_addr (cpu_addr),
    .buf_full   (buf_full),
    .buf_empty  (buf_empty),
    .fence_wait (cpu_valid && is_fence),
    .mem_ready  (mem_ready),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .busy       (ld_busy),
    .rd_want    (ld_req),
    .grant      (ld_grant),
    .ld_addr    (ld_addr),
    .done       (ld_done),
    .done_data  (ld_done_data)
  );

  // memory port: pending load read or head-of-buffer write
  assign drain     = !buf_empty && !ld_grant;
  assign pop       = drain && mem_ready;
  assign mem_valid = ld_grant || drain;
  assign mem_we    = drain;
  assign mem_addr  = drain ? head_addr : ld_addr;
  assign mem_wdata = head_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= (ld_take && fwd_hit) || ld_done;
      if (ld_take && fwd_hit) rsp_data <= fwd_data;
      else if (ld_done)       rsp_data <= ld_done_data;
    end
  end
endmodule

// File: rtl/sb_tso_chk.sv
module sb_tso_chk #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             cpu_valid,
  input logic             cpu_ready,
  input logic [1:0]       cpu_op,
  input logic             rsp_valid,
  input logic             mem_valid,
  input logic             mem_ready,
  input logic             mem_we,
  input logic             mem_rvalid,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             fwd_hit,
  input logic             ld_req
);
  logic rd_out;
  always_ff @(posedge clk) begin
    if (rst) rd_out <= 1'b0;
    else if (mem_valid && mem_ready && !mem_we) rd_out <= 1'b1;
    else if (mem_rvalid) rd_out <= 1'b0;
  end

  // R7
  one_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_ready && !mem_we) |-> !rd_out);

  // R5
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    (fifo_cnt == CNT_W'(DEPTH) && cpu_op == 2'b01) |-> !cpu_ready);

  // R6
  fence_drained_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && cpu_op[1]) |-> (fifo_cnt == '0));

  // R1
  fwd_resp_chk: assert property (@(posedge clk) disable iff (rst)
    (cpu_valid && cpu_ready && cpu_op == 2'b00 && fwd_hit) |=> rsp_valid);

  // R8
  drain_first_chk: assert property (@(posedge clk) disable iff (rst)
    (ld_req && mem_valid && mem_we) |-> (fifo_cnt == CNT_W'(DEPTH) || (cpu_valid && cpu_op[1])));

  // R4
  write_source_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_valid && mem_we) |-> (fifo_cnt != '0));
endmodule

bind sb_tso_top sb_tso_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_valid  (cpu_valid),
  .cpu_ready  (cpu_ready),
  .cpu_op     (cpu_op),
  .rsp_valid  (rsp_valid),
  .mem_valid  (mem_valid),
  .mem_ready  (mem_ready),
  .mem_we     (mem_we),
  .mem_rvalid (mem_rvalid),
  .fifo_cnt   (fifo_cnt),
  .fwd_hit    (fwd_hit),
  .ld_req     (ld_req)
);

// File: tb/test_sb_tso_top.sv
`timescale 1ns/1ps
module test_sb_tso_top;
  localparam int AW = 16;
  localparam int DW = 32;
  localparam int DEPTH = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          cpu_valid, cpu_ready;
  logic [1:0]    cpu_op;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          rsp_valid;
  logic [DW-1:0] rsp_data;
  logic          mem_valid, mem_ready, mem_we, mem_rvalid;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata;
  logic          wr_stall;

  always #2.5 clk = ~clk;

  sb_tso_top #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH)) i_sb_tso_top (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_op(cpu_op), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .mem_valid(mem_valid),
    .mem_ready(mem_ready), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  // memory model: writes land at handshake, reads answer one cycle later
  logic [DW-1:0] phys [64];
  logic [AW-1:0] got_wa [64];
  logic [DW-1:0] got_wd [64];
  int            got_n;
  assign mem_ready = mem_we ? !wr_stall : 1'b1;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 64; i++) phys[i] <= 32'h1000 + i;
      got_n      <= 0;
      mem_rvalid <= 1'b0;
      mem_rdata  <= '0;
    end else begin
      mem_rvalid <= 1'b0;
      if (mem_valid && mem_ready && mem_we) begin
        phys[mem_addr[5:0]] <= mem_wdata;
        got_wa[got_n] <= mem_addr;
        got_wd[got_n] <= mem_wdata;
        got_n <= got_n + 1;
      end
      if (mem_valid && mem_ready && !mem_we) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= phys[mem_addr[5:0]];
      end
    end
  end

  int n_chk = 0;
  int n_bad = 0;
  logic [AW-1:0] exp_wa [64];
  logic [DW-1:0] exp_wd [64];
  int exp_n = 0;

  task automatic check(input string req, input logic [DW-1:0] got, input logic [DW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input int a, input logic [DW-1:0] d);
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = op; cpu_addr = AW'(a); cpu_wdata = d;
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    if (op == 2'b01) begin
      exp_wa[exp_n] = AW'(a); exp_wd[exp_n] = d; exp_n++;
    end
  endtask

  task automatic load_get(input int a, output logic [DW-1:0] v, output int lat);
    drive(2'b00, a, '0);
    lat = 0;
    while (!rsp_valid && lat < 100) begin @(posedge clk); #1; lat++; end
    v = rsp_data;
  endtask

  typedef struct packed {
    logic [1:0]  op;
    logic [7:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 8'd3,  32'h0000_00AA, 32'h0},
    '{2'b00, 8'd3,  32'h0,         32'h0000_00AA},
    '{2'b01, 8'd3,  32'h0000_00BB, 32'h0},
    '{2'b00, 8'd3,  32'h0,         32'h0000_00BB},
    '{2'b00, 8'd5,  32'h0,         32'h0000_1005},
    '{2'b10, 8'd0,  32'h0,         32'h0},
    '{2'b00, 8'd3,  32'h0,         32'h0000_00BB},
    '{2'b01, 8'd7,  32'h0000_00CC, 32'h0},
    '{2'b01, 8'd9,  32'h0000_00DD, 32'h0},
    '{2'b00, 8'd7,  32'h0,         32'h0000_00CC},
    '{2'b00, 8'd2,  32'h0,         32'h0000_1002},
    '{2'b11, 8'd0,  32'h0,         32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int lat;
    int w0;
    rst = 1'b1; cpu_valid = 1'b0; cpu_op = 2'b00; cpu_addr = '0; cpu_wdata = '0; wr_stall = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R9 rsp_valid", 32'(rsp_valid), 32'd0);
    check("R9 mem_valid", 32'(mem_valid), 32'd0);
    check("R9 cpu_ready", 32'(cpu_ready), 32'd1);
    rst = 1'b0;

    // vector walk: forwarding and memory loads (R1 R3)
    for (int k = 0; k < NV; k++) begin
      if (VEC[k].op == 2'b00) begin
        load_get(int'(VEC[k].addr), v, lat);
        check("R1 R3 vector load", v, VEC[k].exp);
      end else begin
        drive(VEC[k].op, int'(VEC[k].addr), VEC[k].data);
      end
    end

    // R4 and R3: stalled writes stay out of memory while a read passes them
    wr_stall = 1'b1;
    drive(2'b01, 20, 32'h55);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R4 memory untouched", phys[20], 32'h1014);
    w0 = got_n;
    load_get(21, v, lat);
    check("R3 read passes store", v, 32'h1015);
    check("R3 no write meanwhile", 32'(got_n), 32'(w0));

    // R5: fill the buffer, store blocked, hit load accepted
    for (int i = 0; i < DEPTH - 1; i++) drive(2'b01, 40 + i, 32'h200 + i);
    @(negedge clk);
    cpu_op = 2'b01; cpu_addr = AW'(50);
    check("R5 store blocked when full", 32'(cpu_ready), 32'd0);
    load_get(20, v, lat);
    check("R5 load accepted when full", v, 32'h55);
    check("R1 forward latency", 32'(lat), 32'd0);

    // R7 and R8: missing load with full buffer
    drive(2'b00, 30, '0);
    cpu_op = 2'b01;
    check("R7 ready low during load", 32'(cpu_ready), 32'd0);
    @(negedge clk);
    check("R8 drain first when full", 32'(mem_valid && mem_we), 32'd1);
    wr_stall = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 100) begin @(posedge clk); #1; lat++; end
    check("R8 load answered", rsp_data, 32'h101E);

    // R6: fence waits for the buffer to empty
    wr_stall = 1'b1;
    @(negedge clk);
    cpu_valid = 1'b1; cpu_op = 2'b10;
    repeat (3) begin
      @(negedge clk);
      check("R6 fence held", 32'(cpu_ready), 32'd0);
    end
    wr_stall = 1'b0;
    while (!cpu_ready) @(negedge clk);
    @(posedge clk); #1;
    cpu_valid = 1'b0;
    check("R6 all stores written", 32'(got_n), 32'(exp_n));
    check("R6 last store in memory", phys[46], 32'h206);

    // R2: write order at the memory port
    for (int i = 0; i < exp_n; i++) begin
      check("R2 write addr order", 32'(got_wa[i]), 32'(exp_wa[i]));
      check("R2 write data order", got_wd[i], exp_wd[i]);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule